// File: doc/BRIEF.md
# Eight-Bit Timer with Two Buffered Compare Channels

This block is an 8-bit timer/counter with two output compare channels, here called A and B. A clock selector picks the event that advances the counter. The choices are a tick divided down from the system clock, a tick from an external oscillator that has already been brought into this clock domain, or no tick at all. The counter has four modes:

- free-running;
- clear on a match with channel A;
- single-slope PWM;
- dual-slope (phase-correct) PWM, which counts up to 0xFF and then back down to 0x00.

Each channel keeps a software-written buffer value and an active compare value. The active value is the one compared with the counter. On a match, the channel raises its event flag and drives its waveform pin according to a selectable action. An overflow event has its own flag. Each flag has an enable bit, and any enabled flag that is set drives one registered interrupt line.

Software reaches the block through a simple port. A write takes effect on the clock edge on which `wr_en` is sampled high. A read returns data one cycle after `rd_addr` is presented.

The register map is as follows:

| Address | Contents |
|---|---|
| 0 | CFG: mode in [1:0] (0 free-running, 1 clear-on-match, 2 single-slope PWM, 3 dual-slope PWM), channel A action in [3:2], channel B action in [5:4] |
| 1 | SRC: tick select in [2:0] (0 off; 1..7 divide by 1, 8, 32, 64, 128, 256, 1024), external tick select in [3] |
| 2 | COUNT |
| 3 | Channel A buffer |
| 4 | Channel B buffer |
| 5 | FLAGS: [0] overflow, [1] A match, [2] B match |
| 6 | ENABLE: interrupt enable bits, laid out like FLAGS |

Top module: `tmr8_dualcmp`

## Requirements
- R1: After reset, COUNT, FLAGS, CFG, both waveform pins and the interrupt line read 0.
- R2: While the tick select in SRC[2:0] is 0, COUNT holds its value and no flag is set.
- R3: With SRC[3]=0, SRC[2:0] values 1, 2, 4 and 7 give exactly one count per 1, 8, 64 and 1024 system clocks respectively.
- R4: With SRC[3]=1 and SRC[2:0] nonzero, COUNT advances once per one-cycle pulse on `ext_tick_i`, through a single synchronizing flop.
- R5: In free-running mode, COUNT wraps from 0xFF to 0x00 and sets FLAGS[0].
- R6: In clear-on-match mode, COUNT goes to 0x00 on the tick after it equals the active channel A value, and FLAGS[1] is set; FLAGS[0] stays clear while COUNT never reaches 0xFF.
- R7: A tick with COUNT equal to a channel's active value sets that channel's flag (A in FLAGS[1], B in FLAGS[2]). With action 1 (toggle), the tick inverts the channel's pin.
- R8: In single-slope PWM, buffer writes reach the active value only on the tick at 0xFF. With action 2, the pin goes high on that tick and low on a match. The wrap from 0xFF sets FLAGS[0].
- R9: In dual-slope PWM, COUNT turns from 0xFF to 0xFE and from 0x00 to 0x01. FLAGS[0] sets when COUNT steps down to 0x00. With action 2, the pin clears on an up-count match and sets on a down-count match.
- R10: Writing ones to FLAGS clears only those bits. The interrupt line is high one cycle after any flag is set together with its enable bit in ENABLE, and low otherwise.
- R11: Buffer and configuration registers read back the last value written, with `rd_data` valid one cycle after `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Registered read data |
| ext_tick_i | input | 1 | Pre-synchronized external oscillator tick |
| cmp_a_o | output | 1 | Channel A waveform |
| cmp_b_o | output | 1 | Channel B waveform |
| irq_o | output | 1 | Combined registered interrupt request |

## Verification
A register write takes effect at the edge that samples it. A count, flag or pin change caused by a tick appears at that tick's edge. An internal tick comes from the divider directly. An external pulse needs one extra edge to pass the synchronizer. The interrupt line and `rd_data` each trail their source by one further edge.

The bench starts and stops the tick source with register writes that are a known number of edges apart, so a run counts a fixed number of ticks whatever the divider phase. Each expected item is queued when its stimulus ends and compared one edge later, at the negative clock edge. For reads, that edge is the one that captures `rd_data`.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  localparam int A_CFG  = 0;
  localparam int A_SRC  = 1;
  localparam int A_CNT  = 2;
  localparam int A_BUFA = 3;
  localparam int A_FLAG = 5;
  localparam int A_ENA  = 6;

  typedef enum logic [1:0] {
    MD_FREE = 2'd0,
    MD_CTC  = 2'd1,
    MD_FPWM = 2'd2,
    MD_DPWM = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_TOGGLE = 2'd1,
    ACT_CLEAR  = 2'd2,
    ACT_SET    = 2'd3
  } act_e;
endpackage

// File: rtl/tmr8_tickgen.sv
module tmr8_tickgen #(
  parameter int PRESC_W = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] sel,
  input  logic       ext_sel,
  input  logic       ext_tick_i,
  output logic       tick_o
);
  logic [PRESC_W-1:0] presc_q;
  logic [PRESC_W-1:0] mask;
  logic               ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      presc_q <= '0;
      ext_q   <= 1'b0;
    end else begin
      presc_q <= presc_q + 1'b1;
      ext_q   <= ext_tick_i;
    end
  end

  always_comb begin
    case (sel)
      3'd2:    mask = PRESC_W'(7);
      3'd3:    mask = PRESC_W'(31);
      3'd4:    mask = PRESC_W'(63);
      3'd5:    mask = PRESC_W'(127);
      3'd6:    mask = PRESC_W'(255);
      3'd7:    mask = PRESC_W'(1023);
      default: mask = '0;
    endcase
  end

  assign tick_o = (sel != 3'd0) &&
                  (ext_sel ? ext_q : ((presc_q & mask) == mask));
endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode,
  input  logic         tick,
  input  logic         ld_en,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] top_ctc,
  output logic [W-1:0] cnt_q,
  output logic         dir_down_q,
  output logic         at_top,
  output logic         ovf_evt
);
  localparam logic [W-1:0] MAXV = '1;
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] top;

  assign top    = (mode == MD_CTC) ? top_ctc : MAXV;
  assign at_top = tick && (cnt_q == top);

  always_comb begin
    if (mode == MD_DPWM) ovf_evt = tick && dir_down_q && (cnt_q == ONE);
    else                 ovf_evt = tick && (cnt_q == MAXV);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q      <= '0;
      dir_down_q <= 1'b0;
    end else begin
      if (mode != MD_DPWM) dir_down_q <= 1'b0;
      if (ld_en) begin
        cnt_q <= ld_val;
      end else if (tick) begin
        case (mode)
          MD_CTC: cnt_q <= (cnt_q == top) ? '0 : cnt_q + 1'b1;
          MD_DPWM: begin
            if (!dir_down_q) begin
              if (cnt_q == MAXV) begin
                dir_down_q <= 1'b1;
                cnt_q      <= cnt_q - 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end else begin
              if (cnt_q == '0) begin
                dir_down_q <= 1'b0;
                cnt_q      <= ONE;
              end else begin
                cnt_q <= cnt_q - 1'b1;
              end
            end
          end
          default: cnt_q <= cnt_q + 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr8_cmpch.sv
module tmr8_cmpch
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode,
  input  act_e         act,
  input  logic         buf_we,
  input  logic [W-1:0] buf_wd,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         dir_down,
  input  logic         at_top,
  output logic [W-1:0] buf_q,
  output logic [W-1:0] act_q,
  output logic         match_evt,
  output logic         wave_q
);
  logic pwm_mode;

  assign pwm_mode  = (mode == MD_FPWM) || (mode == MD_DPWM);
  assign match_evt = tick && (cnt == act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (buf_we) buf_q <= buf_wd;
      if (!pwm_mode && buf_we) act_q <= buf_wd;
      else if (pwm_mode && at_top) act_q <= buf_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wave_q <= 1'b0;
    end else if (act == ACT_TOGGLE) begin
      if (match_evt) wave_q <= ~wave_q;
    end else if (act != ACT_NONE) begin
      case (mode)
        MD_FPWM: begin
          if (at_top)         wave_q <= (act == ACT_CLEAR);
          else if (match_evt) wave_q <= (act == ACT_SET);
        end
        MD_DPWM: begin
          if (match_evt) wave_q <= dir_down ^ (act == ACT_SET);
        end
        default: begin
          if (match_evt) wave_q <= (act == ACT_SET);
        end
      endcase
    end
  end
endmodule

// File: rtl/tmr8_dualcmp.sv
module tmr8_dualcmp
  import tmr8_pkg::*;
#(
  parameter int W       = 8,
  parameter int PRESC_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              ext_tick_i,
  output logic              cmp_a_o,
  output logic              cmp_b_o,
  output logic              irq_o
);
  localparam int NF = NCH + 1;
  localparam int CW = 2 + 2 * NCH;

  logic [1:0]       mode_q;
  logic [2*NCH-1:0] act_q;
  logic [2:0]       sel_q;
  logic             ext_sel_q;
  logic [NF-1:0]    flags_q;
  logic [NF-1:0]    ena_q;
  logic             irq_q;
  logic [W-1:0]     rd_q;
  logic [W-1:0]     rd_mux;

  mode_e            mode;
  logic             tick;
  logic [W-1:0]     cnt_q;
  logic             dir_down;
  logic             at_top;
  logic             ovf_evt;
  logic [W-1:0]     ch_buf [NCH];
  logic [W-1:0]     ch_act [NCH];
  logic [NCH-1:0]   ch_match;
  logic [NCH-1:0]   ch_wave;
  logic [NF-1:0]    flag_clr;
  logic [NF-1:0]    flag_set;
  logic [W-1:0]     ocr_a_act;
  logic [W-1:0]     ocr_b_act;

  logic wr_cfg, wr_src, wr_cnt, wr_flag, wr_ena;
  assign wr_cfg  = wr_en && (wr_addr == ADDR_W'(A_CFG));
  assign wr_src  = wr_en && (wr_addr == ADDR_W'(A_SRC));
  assign wr_cnt  = wr_en && (wr_addr == ADDR_W'(A_CNT));
  assign wr_flag = wr_en && (wr_addr == ADDR_W'(A_FLAG));
  assign wr_ena  = wr_en && (wr_addr == ADDR_W'(A_ENA));

  assign mode     = mode_e'(mode_q);
  assign flag_clr = wr_flag ? wr_data[NF-1:0] : '0;
  assign flag_set = {ch_match, ovf_evt};

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      act_q     <= '0;
      sel_q     <= '0;
      ext_sel_q <= 1'b0;
      flags_q   <= '0;
      ena_q     <= '0;
      irq_q     <= 1'b0;
      rd_q      <= '0;
    end else begin
      if (wr_cfg) begin
        mode_q <= wr_data[1:0];
        act_q  <= wr_data[CW-1:2];
      end
      if (wr_src) begin
        sel_q     <= wr_data[2:0];
        ext_sel_q <= wr_data[3];
      end
      if (wr_ena) ena_q <= wr_data[NF-1:0];
      flags_q <= (flags_q & ~flag_clr) | flag_set;
      irq_q   <= |(flags_q & ena_q);
      rd_q    <= rd_mux;
    end
  end

  tmr8_tickgen #(.PRESC_W(PRESC_W)) u_tick (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel_q),
    .ext_sel    (ext_sel_q),
    .ext_tick_i (ext_tick_i),
    .tick_o     (tick)
  );

  tmr8_counter #(.W(W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .tick       (tick),
    .ld_en      (wr_cnt),
    .ld_val     (wr_data),
    .top_ctc    (ch_act[0]),
    .cnt_q      (cnt_q),
    .dir_down_q (dir_down),
    .at_top     (at_top),
    .ovf_evt    (ovf_evt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic buf_we;
    assign buf_we = wr_en && (wr_addr == ADDR_W'(A_BUFA + i));
    tmr8_cmpch #(.W(W)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode),
      .act       (act_e'(act_q[2*i +: 2])),
      .buf_we    (buf_we),
      .buf_wd    (wr_data),
      .tick      (tick),
      .cnt       (cnt_q),
      .dir_down  (dir_down),
      .at_top    (at_top),
      .buf_q     (ch_buf[i]),
      .act_q     (ch_act[i]),
      .match_evt (ch_match[i]),
      .wave_q    (ch_wave[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      ADDR_W'(A_CFG):      rd_mux[CW-1:0] = {act_q, mode_q};
      ADDR_W'(A_SRC):      rd_mux[3:0]    = {ext_sel_q, sel_q};
      ADDR_W'(A_CNT):      rd_mux         = cnt_q;
      ADDR_W'(A_BUFA):     rd_mux         = ch_buf[0];
      ADDR_W'(A_BUFA + 1): rd_mux         = ch_buf[1];
      ADDR_W'(A_FLAG):     rd_mux[NF-1:0] = flags_q;
      ADDR_W'(A_ENA):      rd_mux[NF-1:0] = ena_q;
      default:             rd_mux         = '0;
    endcase
  end

  assign ocr_a_act = ch_act[0];
  assign ocr_b_act = ch_act[1];
  assign cmp_a_o   = ch_wave[0];
  assign cmp_b_o   = ch_wave[1];
  assign irq_o     = irq_q;
  assign rd_data   = rd_q;
endmodule

// File: rtl/tmr8_dualcmp_chk.sv
module tmr8_dualcmp_chk
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [1:0]        mode,
  input logic [2:0]        sel,
  input logic              tick,
  input logic [W-1:0]      cnt,
  input logic [W-1:0]      ocra,
  input logic [W-1:0]      ocrb,
  input logic [NCH:0]      flags,
  input logic [NCH:0]      ena,
  input logic              irq
);
  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == ADDR_W'(A_CNT));

  // R2
  clock_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel == 3'd0 && !cnt_wr) |=> $stable(cnt));

  // R5
  free_wrap_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MD_FREE && cnt == '1 && !cnt_wr) |=> (cnt == '0 && flags[0]));

  // R6
  ctc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MD_CTC && cnt == ocra && !cnt_wr) |=> (cnt == '0));

  // R9
  dual_turn_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && mode == MD_DPWM && cnt == '1 && !cnt_wr) |=> (cnt == W'('1 - 1)));

  // R7
  match_b_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == ocrb) |=> flags[2]);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((flags & ena) == '0) |=> !irq);
endmodule

bind tmr8_dualcmp tmr8_dualcmp_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .mode    (mode_q),
  .sel     (sel_q),
  .tick    (tick),
  .cnt     (cnt_q),
  .ocra    (ocr_a_act),
  .ocrb    (ocr_b_act),
  .flags   (flags_q),
  .ena     (ena_q),
  .irq     (irq_q)
);

// File: tb/test_tmr8_dualcmp.sv
module test_tmr8_dualcmp;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       ext_tick_i = 1'b0;
  logic       cmp_a_o, cmp_b_o, irq_o;

  localparam logic [2:0] CFG = 3'd0, SRC = 3'd1, CNT = 3'd2, BUFA = 3'd3,
                         BUFB = 3'd4, FLG = 3'd5, ENA = 3'd6;

  typedef struct {
    int         kind;   // 0 read, 1 pin A, 2 pin B, 3 irq
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  logic  req = 1'b0;
  logic  req_q = 1'b0;
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  always #10 clk = ~clk;

  tmr8_dualcmp i_tmr8_dualcmp (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_tick_i(ext_tick_i),
    .cmp_a_o(cmp_a_o), .cmp_b_o(cmp_b_o), .irq_o(irq_o)
  );

  always @(posedge clk) req_q <= req;

  // monitor: compares one edge after the driver queued the item
  always @(negedge clk) begin
    if (req_q && q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rd_data;
        1:       act = {7'd0, cmp_a_o};
        2:       act = {7'd0, cmp_b_o};
        default: act = {7'd0, irq_o};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic expect_item(input int kind, input logic [2:0] a,
                             input logic [7:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    if (kind == 0) rd_addr = a;
    q.push_back(it);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  // tick source on for exactly n edges after the enabling write
  task automatic run(input logic [7:0] src, input int n);
    wr(SRC, src);
    repeat (n - 1) @(negedge clk);
    wr(SRC, 8'h00);
  endtask

  task automatic drain();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    expect_item(0, CNT, 8'h00, "R1 count");
    expect_item(0, FLG, 8'h00, "R1 flags");
    expect_item(0, CFG, 8'h00, "R1 cfg");
    expect_item(1, 0, 8'h00, "R1 pin A");
    expect_item(3, 0, 8'h00, "R1 irq");
    // R11 readback
    wr(BUFA, 8'h5A);
    wr(BUFB, 8'h80);
    expect_item(0, BUFA, 8'h5A, "R11 buffer A");
    wr(CFG, 8'h24);
    expect_item(0, CFG, 8'h24, "R11 cfg");
    wr(CFG, 8'h00);
    // R2 clock off
    wr(FLG, 8'h07);
    wr(CNT, 8'd5);
    repeat (40) @(negedge clk);
    expect_item(0, CNT, 8'd5, "R2 count held");
    expect_item(0, FLG, 8'h00, "R2 no flags");
    // R3 prescaler
    wr(CNT, 8'd0); run(8'h01, 20);
    expect_item(0, CNT, 8'd20, "R3 div1");
    wr(CNT, 8'd0); run(8'h02, 80);
    expect_item(0, CNT, 8'd10, "R3 div8");
    wr(CNT, 8'd0); run(8'h04, 640);
    expect_item(0, CNT, 8'd10, "R3 div64");
    wr(CNT, 8'd0); run(8'h07, 2048);
    expect_item(0, CNT, 8'd2, "R3 div1024");
    // R4 external tick
    wr(CNT, 8'd0);
    wr(SRC, 8'h09);
    for (int k = 0; k < 7; k++) begin
      ext_tick_i = 1'b1; @(negedge clk);
      ext_tick_i = 1'b0; repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    wr(SRC, 8'h00);
    expect_item(0, CNT, 8'd7, "R4 ext ticks");
    // R5 wrap and overflow, R10 enable and clear
    wr(FLG, 8'h07); wr(ENA, 8'h01);
    wr(CNT, 8'd254); run(8'h01, 3);
    expect_item(0, CNT, 8'd1, "R5 wrapped count");
    expect_item(0, FLG, 8'h01, "R5 overflow flag");
    expect_item(3, 0, 8'h01, "R10 irq enabled");
    wr(FLG, 8'h01);
    expect_item(3, 0, 8'h00, "R10 irq after clear");
    expect_item(0, FLG, 8'h00, "R10 flag cleared");
    wr(ENA, 8'h00);
    wr(CNT, 8'hFF); run(8'h01, 1);
    drain();
    expect_item(3, 0, 8'h00, "R10 irq masked");
    wr(FLG, 8'h02);
    expect_item(0, FLG, 8'h01, "R10 selective clear");
    // R6 clear-on-match
    wr(CFG, 8'h01); wr(BUFA, 8'd9); wr(FLG, 8'h07);
    wr(CNT, 8'd0); run(8'h01, 25);
    expect_item(0, CNT, 8'd5, "R6 count");
    expect_item(0, FLG, 8'h02, "R6 flags");
    // R7 match toggle on channel B
    wr(CFG, 8'h10); wr(BUFB, 8'd3); wr(FLG, 8'h07);
    wr(CNT, 8'd0); run(8'h01, 5);
    drain();
    expect_item(2, 0, 8'h01, "R7 pin B toggled");
    expect_item(1, 0, 8'h00, "R7 pin A idle");
    expect_item(0, FLG, 8'h04, "R7 B flag");
    // R8 single-slope PWM buffering
    wr(CFG, 8'h22); wr(BUFB, 8'd200);
    expect_item(0, BUFB, 8'd200, "R11 buffer B");
    wr(FLG, 8'h07); wr(CNT, 8'd0); run(8'h01, 5);
    drain();
    expect_item(2, 0, 8'h00, "R8 old value cleared pin");
    expect_item(0, FLG, 8'h04, "R8 old value flagged");
    wr(FLG, 8'h07); wr(CNT, 8'd250); run(8'h01, 6);
    drain();
    expect_item(2, 0, 8'h01, "R8 pin set at top");
    expect_item(0, CNT, 8'd0, "R8 wrapped");
    run(8'h01, 5);
    drain();
    expect_item(2, 0, 8'h01, "R8 new value in use");
    expect_item(0, FLG, 8'h01, "R8 flags");
    // R9 dual-slope
    wr(CFG, 8'h0B);
    wr(CNT, 8'd253); run(8'h01, 5);
    expect_item(0, CNT, 8'd252, "R9 turn at max");
    wr(CNT, 8'd12); run(8'h01, 4);
    drain();
    expect_item(1, 0, 8'h01, "R9 down match sets pin");
    expect_item(0, CNT, 8'd8, "R9 down count");
    wr(FLG, 8'h07); wr(CNT, 8'd2); run(8'h01, 3);
    expect_item(0, CNT, 8'd1, "R9 turn at bottom");
    expect_item(0, FLG, 8'h01, "R9 bottom overflow");
    run(8'h01, 9);
    drain();
    expect_item(1, 0, 8'h00, "R9 up match clears pin");
    expect_item(0, CNT, 8'd10, "R9 up count");
    drain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule